// File: doc/BRIEF.md
# Pipelined Bus Cycle Sequencer

This block turns memory and I/O transfer requests from a simple processor core into external bus cycles. The core offers one request at a time: a word address, byte enables, a three-bit cycle type, write data and a flag marking system-management (SMM) accesses. The sequencer takes the request with a single-cycle handshake. It then drives the address and cycle definition, pulses an active-low address strobe, and waits for the system to return READY. When a read completes, the captured data goes back to the core with a one-clock completion pulse.

The external system can pull the active-low next-address input low while a cycle is still waiting for READY. This lets the following request's address and definition go out early, so the two cycles overlap. At most one such early cycle may be outstanding.

SMM accesses pulse a separate SMM strobe instead of the normal one, but only when a configuration enable input is high. That enable is low after reset. When the enable is low, SMM accesses fall back to the normal strobe.

A hold request floats the strobes and the address group once no cycle is open.

Top module: `pipe_bus_seq`

## Requirements
- R1: While `rst` is high and just after it: `adsN` and `smAdsN` are 1, `reqReady`, `rspValid`, `busDataOe` and `holdAck` are 0, and `smAdsOe` is 0 while `smmStrobeEn` is 0.
- R2: With no cycle open, no hold request and `holdAck` low, a valid request is accepted in the same clock (`reqReady`=1). From the next clock, `busAddr`, `busBe` and `busType` show that request, and one strobe is low for exactly that one clock.
- R3: While exactly one cycle is open, a request is accepted only in a clock where `naN` is 0. Its address and definition go out before the open cycle receives READY.
- R4: While one cycle is open and a second has already been issued, `reqReady` stays 0 whatever `naN` is. Further requests wait for READY on the open cycle.
- R5: A cycle ends only at a clock edge where `busReady` is 1. Every ending gives a one-clock `rspValid` on the next clock. `busReady` while no cycle is open has no effect.
- R6: A read captures `busRdata` at the edge where READY ends it, and presents it on `rspData` with `rspValid`. `rspData` holds its value across writes.
- R7: During the data phase of a write, `busWdata` carries that cycle's own data, even when a later cycle's address is already out.
- R8: A request with `reqSmm`=1 that is accepted while `smmStrobeEn`=1 pulses `smAdsN` instead of `adsN`. All other requests pulse `adsN`. The two strobes are never low together.
- R9: `holdAck` rises one clock after `holdReq` is seen with no cycle open. While `holdAck` is 1, `busAddrOe` and `smAdsOe` are 0 and no request is accepted. `holdAck` falls one clock after `holdReq` drops.
- R10: `smAdsOe` is 1 exactly when `smmStrobeEn` is 1 and `holdAck` is 0.
- R11: Bit 0 of the cycle type marks a write (1 = write). `busDataOe` is 1 exactly while the cycle in its data phase is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smmStrobeEn | input | 1 | Configuration enable for the SMM strobe |
| reqValid | input | 1 | Core request present |
| reqReady | output | 1 | Request accepted this clock |
| reqAddr | input | ADDR_W | Word address |
| reqBe | input | DATA_W/8 | Byte enables |
| reqType | input | 3 | Cycle type, bit 0 = write |
| reqSmm | input | 1 | SMM access flag |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | Cycle completed (one clock) |
| rspData | output | DATA_W | Last read data |
| adsN | output | 1 | Address strobe, active low |
| smAdsN | output | 1 | SMM address strobe, active low |
| busAddrOe | output | 1 | Output enable of address, definition and `adsN` |
| smAdsOe | output | 1 | Output enable of `smAdsN` |
| busAddr | output | ADDR_W | Bus address |
| busBe | output | DATA_W/8 | Bus byte enables |
| busType | output | 3 | Bus cycle definition |
| busWdata | output | DATA_W | Bus write data |
| busDataOe | output | 1 | Write data drive enable |
| busRdata | input | DATA_W | Bus read data |
| busReady | input | 1 | Cycle termination, active high |
| naN | input | 1 | Next-address request, active low |
| holdReq | input | 1 | Bus hold request |
| holdAck | output | 1 | Bus hold granted |

## Verification
A first sweep steps through every order of three consecutive (`reqValid`, `naN`, `busReady`) values. This separates an issue from idle (R2), an early issue under next-address (R3), a blocked third request (R4), and READY with and without a pipelined successor, including READY and next-address arriving in the same clock. A second, long pseudo-random phase adds hold windows and toggles the SMM enable. It shows whether hold waits for open cycles to drain, and whether SMM requests pick the right strobe under both enable values. Write data and read data are random per cycle, so data from a wrong slot or a wrong capture edge shows up as a miscompare.

// File: rtl/pipe_bus_pkg.sv
package pipe_bus_pkg;
  localparam int TYPE_W = 3;
  localparam int WR_BIT = 0;

  typedef struct packed {
    logic loadAddr;
    logic loadCur;
    logic loadPipe;
    logic promote;
    logic endCycle;
    logic dataPhase;
  } bus_strb_t;
endpackage

// File: rtl/pipe_bus_ctrl.sv
module pipe_bus_ctrl
  import pipe_bus_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      reqValid,
  input  logic      reqSmm,
  input  logic      smmStrobeEn,
  input  logic      naN,
  input  logic      busReady,
  input  logic      holdReq,
  output logic      reqReady,
  output logic      holdAck,
  output logic      adsN,
  output logic      smAdsN,
  output bus_strb_t strb
);
  logic curActive, pipeActive, holdAckQ, adsQ, smAdsQ;
  logic issue, endCyc, toCur, toPipe, smmSel;

  always_comb begin
    issue  = !rst && reqValid && !holdReq && !holdAckQ &&
             (!curActive || (!pipeActive && !naN));
    endCyc = curActive && busReady;
    toCur  = issue && (!curActive || endCyc);
    toPipe = issue && curActive && !endCyc;
    smmSel = reqSmm && smmStrobeEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curActive  <= 1'b0;
      pipeActive <= 1'b0;
      holdAckQ   <= 1'b0;
      adsQ       <= 1'b0;
      smAdsQ     <= 1'b0;
    end else begin
      if (endCyc) curActive <= pipeActive || toCur;
      else        curActive <= curActive || issue;
      pipeActive <= toPipe || (pipeActive && !endCyc);
      holdAckQ   <= holdReq && (holdAckQ || !curActive);
      adsQ       <= issue && !smmSel;
      smAdsQ     <= issue && smmSel;
    end
  end

  always_comb begin
    reqReady       = issue;
    holdAck        = holdAckQ;
    adsN           = !adsQ;
    smAdsN         = !smAdsQ;
    strb.loadAddr  = issue;
    strb.loadCur   = toCur;
    strb.loadPipe  = toPipe;
    strb.promote   = endCyc && pipeActive;
    strb.endCycle  = endCyc;
    strb.dataPhase = curActive;
  end

  p_pipe_needs_cur_r4: assert property (@(posedge clk) disable iff (rst)
    pipeActive |-> curActive);
  p_no_third_r4: assert property (@(posedge clk) disable iff (rst)
    (curActive && pipeActive) |-> !reqReady);
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    holdAck |-> (!curActive && !reqReady));
  p_wait_ready_r5: assert property (@(posedge clk) disable iff (rst)
    (curActive && !busReady) |=> curActive);
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(!adsN && !smAdsN));
  p_ads_one_clock_r2: assert property (@(posedge clk) disable iff (rst)
    (!adsN && !reqReady) |=> adsN);
endmodule

// File: rtl/pipe_bus_dpath.sv
module pipe_bus_dpath
  import pipe_bus_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_strb_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0]   reqBe,
  input  logic [TYPE_W-1:0] reqType,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BE_W-1:0]   busBe,
  output logic [TYPE_W-1:0] busType,
  output logic [DATA_W-1:0] busWdata,
  output logic              busDataOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  logic              curWr, pipeWr;
  logic [DATA_W-1:0] curWd, pipeWd;

  always_ff @(posedge clk) begin
    if (rst) begin
      busAddr  <= '0;
      busBe    <= '0;
      busType  <= '0;
      curWr    <= 1'b0;
      pipeWr   <= 1'b0;
      curWd    <= '0;
      pipeWd   <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strb.loadAddr) begin
        busAddr <= reqAddr;
        busBe   <= reqBe;
        busType <= reqType;
      end
      if (strb.loadCur) begin
        curWr <= reqType[WR_BIT];
        curWd <= reqWdata;
      end else if (strb.promote) begin
        curWr <= pipeWr;
        curWd <= pipeWd;
      end
      if (strb.loadPipe) begin
        pipeWr <= reqType[WR_BIT];
        pipeWd <= reqWdata;
      end
      rspValid <= strb.endCycle;
      if (strb.endCycle && !curWr) rspData <= busRdata;
    end
  end

  always_comb begin
    busDataOe = strb.dataPhase && curWr;
    busWdata  = curWd;
  end

  p_rsp_follows_end_r5: assert property (@(posedge clk) disable iff (rst)
    strb.endCycle |=> rspValid);
  p_write_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busDataOe && !strb.endCycle) |=> $stable(busWdata));
endmodule

// File: rtl/pipe_bus_seq.sv
module pipe_bus_seq
  import pipe_bus_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smmStrobeEn,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0]   reqBe,
  input  logic [2:0]        reqType,
  input  logic              reqSmm,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              adsN,
  output logic              smAdsN,
  output logic              busAddrOe,
  output logic              smAdsOe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BE_W-1:0]   busBe,
  output logic [2:0]        busType,
  output logic [DATA_W-1:0] busWdata,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  input  logic              naN,
  input  logic              holdReq,
  output logic              holdAck
);
  bus_strb_t strb;

  pipe_bus_ctrl ctrl_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqSmm(reqSmm),
    .smmStrobeEn(smmStrobeEn), .naN(naN), .busReady(busReady),
    .holdReq(holdReq), .reqReady(reqReady), .holdAck(holdAck),
    .adsN(adsN), .smAdsN(smAdsN), .strb(strb)
  );

  pipe_bus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rst(rst), .strb(strb), .reqAddr(reqAddr), .reqBe(reqBe),
    .reqType(reqType), .reqWdata(reqWdata), .busRdata(busRdata),
    .busAddr(busAddr), .busBe(busBe), .busType(busType),
    .busWdata(busWdata), .busDataOe(busDataOe), .rspValid(rspValid),
    .rspData(rspData)
  );

  always_comb begin
    busAddrOe = !holdAck;
    smAdsOe   = smmStrobeEn && !holdAck;
  end

  p_smm_oe_r10: assert property (@(posedge clk) disable iff (rst)
    smAdsOe |-> (smmStrobeEn && busAddrOe));
  p_smm_off_r8: assert property (@(posedge clk) disable iff (rst)
    (!smmStrobeEn && !$past(smmStrobeEn)) |-> smAdsN);
endmodule

// File: tb/pipe_bus_seq_tb_top.sv
module pipe_bus_seq_tb_top;
  localparam int AW = 30;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smmStrobeEn = 0, reqValid = 0, reqSmm = 0, busReady = 0;
  logic naN = 1, holdReq = 0;
  logic [AW-1:0] reqAddr = '0;
  logic [BW-1:0] reqBe = '0;
  logic [2:0]    reqType = '0;
  logic [DW-1:0] reqWdata = '0, busRdata = '0;
  logic reqReady, rspValid, adsN, smAdsN, busAddrOe, smAdsOe, busDataOe, holdAck;
  logic [DW-1:0] rspData, busWdata;
  logic [AW-1:0] busAddr;
  logic [BW-1:0] busBe;
  logic [2:0]    busType;

  int nChk = 0, nBad = 0;

  always #2 clk = !clk;

  pipe_bus_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  logic mCur = 0, mPipe = 0, mHold = 0, mAds = 0, mSm = 0;
  logic [AW-1:0] mAddr = '0;
  logic [BW-1:0] mBe = '0;
  logic [2:0]    mType = '0;
  logic mCurWr = 0, mPipeWr = 0, mRspV = 0;
  logic [DW-1:0] mCurWd = '0, mPipeWd = '0, mRspD = '0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    logic iss, ends;
    #1;
    iss = reqValid && !holdReq && !mHold && (!mCur || (!mPipe && !naN));
    if (mCur && mPipe)  check("R4 reqReady", reqReady, iss);
    else if (mCur)      check("R3 reqReady", reqReady, iss);
    else                check("R2 reqReady", reqReady, iss);
    check("R2 adsN", adsN, !mAds);
    check("R8 smAdsN", smAdsN, !mSm);
    check("R9 holdAck", holdAck, mHold);
    check("R9 busAddrOe", busAddrOe, !mHold);
    check("R10 smAdsOe", smAdsOe, smmStrobeEn && !mHold);
    if (!mHold) check("R2 address group", {busAddr, busBe, busType}, {mAddr, mBe, mType});
    check("R11 busDataOe", busDataOe, mCur && mCurWr);
    if (mCur && mCurWr) check("R7 busWdata", busWdata, mCurWd);
    check("R5 rspValid", rspValid, mRspV);
    check("R6 rspData", rspData, mRspD);
    ends = mCur && busReady;
    @(posedge clk);
    mRspV <= ends;
    if (ends && !mCurWr) mRspD <= busRdata;
    mHold <= holdReq && (mHold || !mCur);
    mAds  <= iss && !(reqSmm && smmStrobeEn);
    mSm   <= iss && reqSmm && smmStrobeEn;
    if (iss) begin
      mAddr <= reqAddr; mBe <= reqBe; mType <= reqType;
    end
    if (iss && (!mCur || ends)) begin
      mCurWr <= reqType[0]; mCurWd <= reqWdata;
    end else if (ends && mPipe) begin
      mCurWr <= mPipeWr; mCurWd <= mPipeWd;
    end
    if (iss && mCur && !ends) begin
      mPipeWr <= reqType[0]; mPipeWd <= reqWdata;
    end
    if (ends) mCur <= mPipe || (iss && !mPipe);
    else      mCur <= mCur || iss;
    mPipe <= (iss && mCur && !ends) || (mPipe && !ends);
    @(negedge clk);
  endtask

  task automatic randData();
    reqAddr  = AW'($urandom);
    reqBe    = BW'($urandom);
    reqType  = 3'($urandom);
    reqSmm   = 1'($urandom);
    reqWdata = $urandom;
    busRdata = $urandom;
  endtask

  initial begin
    #(4 * 200000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    reqValid = 1; busReady = 1; naN = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 adsN", adsN, 1); check("R1 smAdsN", smAdsN, 1);
    check("R1 reqReady", reqReady, 0); check("R1 rspValid", rspValid, 0);
    check("R1 busDataOe", busDataOe, 0); check("R1 holdAck", holdAck, 0);
    check("R1 smAdsOe", smAdsOe, 0);
    @(negedge clk);
    reqValid = 0; busReady = 0; naN = 1;
    rst = 0;
    @(negedge clk);
    // exhaustive 3-cycle orderings of {reqValid, naN, busReady}
    for (int code = 0; code < 512; code++) begin
      for (int k = 0; k < 3; k++) begin
        reqValid = code[3*k];
        naN      = code[3*k+1];
        busReady = code[3*k+2];
        randData();
        step();
      end
    end
    // random phase with hold windows and SMM enable toggling
    for (int c = 0; c < 4000; c++) begin
      reqValid    = ($urandom % 4) != 0;
      naN         = 1'($urandom);
      busReady    = ($urandom % 5) < 2;
      holdReq     = (c % 400) >= 370;
      smmStrobeEn = ((c / 700) % 2) == 1;
      randData();
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule